// File: doc/BRIEF.md
# Banked GPIO Controller

This block controls 64 general-purpose lines arranged as eight groups of eight. Line n sits in group n/8 and uses bit n mod 8 of every per-group register. Software reads and drives the lines through a small runtime data port of eight byte addresses, one per group. That port can be moved anywhere in a 16-bit I/O space. Line direction and line mode are not set through the runtime port. They live in a configuration space that answers only while logical device 0x07 is selected. That space holds one output-enable byte per group, one simple-I/O enable byte for each of the five lowest groups, and the two bytes of the runtime base address.

A small state machine guards the base address while it is being rewritten, so the data window never sits at an address made of one old byte and one new byte. There are two states. In BASE_STABLE the base is settled. A high-byte write (index 0x62) moves the machine to BASE_HI_PENDING and only stages that byte. A low-byte write (index 0x63) commits the whole base, using the staged high byte if one is pending and the current high byte otherwise, and returns the machine to BASE_STABLE. A further high-byte write while in BASE_HI_PENDING restages the byte and leaves the state unchanged.

Pads are modelled as three separate vectors: sensed input, output value and output enable. A fourth vector reports the mode of each line.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset, all output-enable bits are 0 (every line is an input), all output latches are 0, the runtime base is 0x0000, the base machine is in BASE_STABLE, and the simple-I/O enables of groups 0 to 4 are 0.
- R2: Configuration reads and writes take effect only while cfg_ldn equals 0x07. With any other value, writes change nothing and reads return 0x00.
- R3: A write to index 0x62 only stages the high base byte, and reads of 0x62 and 0x63 keep returning the committed base. A write to index 0x63 commits {staged or current high byte, written low byte} in the following cycle.
- R4: Index 0xC8+g (g = 0..7) is the output-enable byte of group g. Bit b set makes pad_oe[8g+b] equal 1 (driven), and bit b clear makes the line an input. The index reads back the stored byte.
- R5: Index 0xC0+g for g = 0..4 holds the simple-I/O enable byte of group g. It reads back and appears on line_simple[8g+7:8g]. Indices 0xC5 to 0xC7 read 0x00 and ignore writes. line_simple[63:40] is always 1 (fixed mode).
- R6: An io_wr to base+g stores io_wdata in the output latch of group g, and that latch appears on pad_out[8g+7:8g]. A line reaches the pad only when its output-enable bit is set.
- R7: A read at base+g returns pad_in[8g+7:8g] on io_rdata in the same cycle (combinational).
- R8: When the base is 0x0000 the runtime port ignores writes, and io_rdata is 0x00.
- R9: The window covers base to base+7 with no wrap past 0xFFFF. Addresses outside it leave the latches unchanged and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ldn | input | 8 | Currently selected logical device number |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | 16 | Runtime I/O address |
| io_wr | input | 1 | Runtime write strobe |
| io_wdata | input | 8 | Runtime write data |
| io_rdata | output | 8 | Runtime read data (combinational) |
| pad_in | input | 64 | Sensed pad levels |
| pad_out | output | 64 | Output latch value per line |
| pad_oe | output | 64 | Output enable per line |
| line_simple | output | 64 | Simple-I/O mode per line |

## Verification
The assertions check four rules on every cycle:
- the base changes only after a low-byte commit;
- a high-byte write always leaves the machine in BASE_HI_PENDING;
- writes from a foreign logical device never move the output enables;
- the latches stay still without a runtime write, and the data port reads zero while disabled.

Other behaviour needs the bench's scenarios:
- that a staged byte combines correctly with the later low byte;
- that the window stops at 0xFFFF;
- that reads mix driven latch bits with external levels by direction;
- that the unimplemented mode indices discard data.

Those scenarios run directed sequences and several hundred seeded random configuration and runtime accesses against a bench-side model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    typedef enum logic [0:0] {
        BASE_STABLE     = 1'b0,
        BASE_HI_PENDING = 1'b1
    } base_state_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int          NUM_GROUPS  = 8,
    parameter int          GROUP_W     = 8,
    parameter int          NUM_SIO     = 5,
    parameter logic [7:0]  LDN_ID      = 8'h07,
    parameter logic [7:0]  IDX_BASE_HI = 8'h62,
    parameter logic [7:0]  IDX_BASE_LO = 8'h63,
    parameter logic [7:0]  IDX_OE0     = 8'hC8,
    parameter logic [7:0]  IDX_SIO0    = 8'hC0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    cfg_ldn,
    input  logic [7:0]                    cfg_idx,
    input  logic                          cfg_wr,
    input  logic [GROUP_W-1:0]            cfg_wdata,
    output logic [GROUP_W-1:0]            cfg_rdata,
    output logic [NUM_GROUPS*GROUP_W-1:0] oe_flat,
    output logic [NUM_GROUPS*GROUP_W-1:0] sio_flat,
    output logic [2*GROUP_W-1:0]          rt_base
);
    localparam int LINES  = NUM_GROUPS * GROUP_W;
    localparam int BASE_W = 2 * GROUP_W;

    logic dev_sel;
    logic wr_hit;
    assign dev_sel = (cfg_ldn == LDN_ID);
    assign wr_hit  = cfg_wr && dev_sel;

    // Per-group direction and mode storage
    logic [GROUP_W-1:0] oe_q  [NUM_GROUPS];
    logic [GROUP_W-1:0] sio_q [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [7:0] OE_IDX  = 8'(int'(IDX_OE0) + g);
        localparam logic [7:0] SIO_IDX = 8'(int'(IDX_SIO0) + g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                oe_q[g] <= '0;
            else if (wr_hit && cfg_idx == OE_IDX)
                oe_q[g] <= cfg_wdata;
        end
        assign oe_flat[g*GROUP_W +: GROUP_W] = oe_q[g];

        if (g < NUM_SIO) begin : g_sio
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sio_q[g] <= '0;
                else if (wr_hit && cfg_idx == SIO_IDX)
                    sio_q[g] <= cfg_wdata;
            end
            assign sio_flat[g*GROUP_W +: GROUP_W] = sio_q[g];
        end else begin : g_fixed
            assign sio_q[g] = '0;
            assign sio_flat[g*GROUP_W +: GROUP_W] = '1;
        end
    end

    // Base address update machine
    base_state_e         state_q, state_d;
    logic [GROUP_W-1:0]  stage_q;
    logic [BASE_W-1:0]   base_q;
    logic                hi_wr, lo_wr;

    assign hi_wr = wr_hit && (cfg_idx == IDX_BASE_HI);
    assign lo_wr = wr_hit && (cfg_idx == IDX_BASE_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BASE_STABLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BASE_STABLE:     if (hi_wr) state_d = BASE_HI_PENDING;
            BASE_HI_PENDING: if (lo_wr) state_d = BASE_STABLE;
            default:         state_d = BASE_STABLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            base_q  <= '0;
        end else begin
            unique case (state_q)
                BASE_STABLE: begin
                    if (hi_wr) stage_q <= cfg_wdata;
                    if (lo_wr) base_q  <= {base_q[BASE_W-1:GROUP_W], cfg_wdata};
                end
                BASE_HI_PENDING: begin
                    if (hi_wr) stage_q <= cfg_wdata;
                    if (lo_wr) base_q  <= {stage_q, cfg_wdata};
                end
                default: ;
            endcase
        end
    end
    assign rt_base = base_q;

    // Read mux
    always_comb begin
        cfg_rdata = '0;
        if (dev_sel) begin
            if (cfg_idx == IDX_BASE_HI) cfg_rdata = base_q[BASE_W-1:GROUP_W];
            if (cfg_idx == IDX_BASE_LO) cfg_rdata = base_q[GROUP_W-1:0];
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (cfg_idx == 8'(int'(IDX_OE0) + g)) cfg_rdata = oe_q[g];
                if (g < NUM_SIO && cfg_idx == 8'(int'(IDX_SIO0) + g)) cfg_rdata = sio_q[g];
            end
        end
    end

    AST_BASE_ONLY_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> $stable(base_q)); // R3
    AST_HI_GOES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (state_q == BASE_HI_PENDING)); // R3
    AST_FOREIGN_LDN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !dev_sel) |=> $stable(oe_flat)); // R2

    logic unused_ok;
    assign unused_ok = ^{LINES};
endmodule

// File: rtl/gpio_rt_port.sv
module gpio_rt_port #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int ADDR_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic                          io_wr,
    input  logic [GROUP_W-1:0]            io_wdata,
    output logic [GROUP_W-1:0]            io_rdata,
    input  logic [ADDR_W-1:0]             rt_base,
    input  logic [NUM_GROUPS*GROUP_W-1:0] pad_in,
    output logic [NUM_GROUPS*GROUP_W-1:0] latch_flat
);
    logic [ADDR_W:0]   diff;
    logic              in_win;

    // 17-bit difference: the top bit flags an address below the base
    assign diff   = {1'b0, io_addr} - {1'b0, rt_base};
    assign in_win = (rt_base != '0) && !diff[ADDR_W] &&
                    (diff[ADDR_W-1:0] < ADDR_W'(NUM_GROUPS));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                latch_flat[g*GROUP_W +: GROUP_W] <= '0;
            else if (io_wr && in_win && diff[ADDR_W-1:0] == ADDR_W'(g))
                latch_flat[g*GROUP_W +: GROUP_W] <= io_wdata;
        end
    end

    always_comb begin
        io_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (in_win && diff[ADDR_W-1:0] == ADDR_W'(g))
                io_rdata = pad_in[g*GROUP_W +: GROUP_W];
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(latch_flat)); // R6
    AST_DISABLED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_base == '0) |-> (io_rdata == '0)); // R8
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int NUM_SIO    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    cfg_ldn,
    input  logic [7:0]                    cfg_idx,
    input  logic                          cfg_wr,
    input  logic [GROUP_W-1:0]            cfg_wdata,
    output logic [GROUP_W-1:0]            cfg_rdata,
    input  logic [2*GROUP_W-1:0]          io_addr,
    input  logic                          io_wr,
    input  logic [GROUP_W-1:0]            io_wdata,
    output logic [GROUP_W-1:0]            io_rdata,
    input  logic [NUM_GROUPS*GROUP_W-1:0] pad_in,
    output logic [NUM_GROUPS*GROUP_W-1:0] pad_out,
    output logic [NUM_GROUPS*GROUP_W-1:0] pad_oe,
    output logic [NUM_GROUPS*GROUP_W-1:0] line_simple
);
    localparam int ADDR_W = 2 * GROUP_W;

    logic [ADDR_W-1:0] rt_base;

    gpio_cfg_regs #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .NUM_SIO(NUM_SIO)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_ldn(cfg_ldn), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .oe_flat(pad_oe), .sio_flat(line_simple), .rt_base(rt_base)
    );

    gpio_rt_port #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)
    ) u_rt (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .rt_base(rt_base), .pad_in(pad_in),
        .latch_flat(pad_out)
    );
endmodule

// File: tb/tb_banked_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_banked_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_ldn = 8'h07, cfg_idx = 8'h00, cfg_wdata = 8'h00;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h0, io_rdata;
    logic [63:0] pad_in, pad_out, pad_oe, line_simple;
    logic [63:0] ext = 64'h0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // External world: driven lines loop back, others follow ext
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    banked_gpio_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ldn(cfg_ldn), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .line_simple(line_simple)
    );

    // Bench model
    logic [7:0]  m_oe [8];
    logic [7:0]  m_sio[8];
    logic [7:0]  m_lat[8];
    logic [15:0] m_base = 16'h0;
    logic [7:0]  m_stage = 8'h0;
    bit          m_pend = 0;

    function automatic logic [63:0] flat(input logic [7:0] a [8]);
        logic [63:0] r;
        for (int g = 0; g < 8; g++) r[g*8 +: 8] = a[g];
        return r;
    endfunction

    function automatic logic [63:0] exp_simple();
        logic [63:0] r = '1;
        for (int g = 0; g < 5; g++) r[g*8 +: 8] = m_sio[g];
        return r;
    endfunction

    function automatic logic [7:0] exp_cfg(input logic [7:0] ldn, input logic [7:0] idx);
        if (ldn != 8'h07) return 8'h00;
        if (idx == 8'h62) return m_base[15:8];
        if (idx == 8'h63) return m_base[7:0];
        if (idx >= 8'hC8 && idx <= 8'hCF) return m_oe[idx - 8'hC8];
        if (idx >= 8'hC0 && idx <= 8'hC4) return m_sio[idx - 8'hC0];
        return 8'h00;
    endfunction

    function automatic bit in_win(input logic [15:0] a);
        logic [16:0] d = {1'b0, a} - {1'b0, m_base};
        return (m_base != 0) && !d[16] && (d[15:0] < 16'd8);
    endfunction

    function automatic logic [7:0] exp_io(input logic [15:0] a);
        logic [63:0] pin;
        logic [15:0] g;
        if (!in_win(a)) return 8'h00;
        g = a - m_base;
        pin = (flat(m_oe) & flat(m_lat)) | (~flat(m_oe) & ext);
        return pin[g[2:0]*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] ldn, input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_ldn = ldn; cfg_idx = idx; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_ldn = 8'h07;
        if (ldn == 8'h07) begin
            if (idx == 8'h62) begin m_stage = d; m_pend = 1; end
            else if (idx == 8'h63) begin
                m_base = {m_pend ? m_stage : m_base[15:8], d}; m_pend = 0;
            end
            else if (idx >= 8'hC8 && idx <= 8'hCF) m_oe[idx - 8'hC8] = d;
            else if (idx >= 8'hC0 && idx <= 8'hC4) m_sio[idx - 8'hC0] = d;
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] g;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (in_win(a)) begin g = a - m_base; m_lat[g[2:0]] = d; end
    endtask

    task automatic cfg_read_chk(input string tag, input logic [7:0] ldn, input logic [7:0] idx);
        cfg_ldn = ldn; cfg_idx = idx; #1;
        chk(tag, {56'h0, cfg_rdata}, {56'h0, exp_cfg(ldn, idx)});
        cfg_ldn = 8'h07;
    endtask

    task automatic io_read_chk(input string tag, input logic [15:0] a);
        io_addr = a; #1;
        chk(tag, {56'h0, io_rdata}, {56'h0, exp_io(a)});
    endtask

    task automatic chk_pads(input string tag);
        chk({tag, " pad_oe"}, pad_oe, flat(m_oe));
        chk({tag, " pad_out"}, pad_out, flat(m_lat));
        chk({tag, " line_simple"}, line_simple, exp_simple());
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 8; g++) begin m_oe[g] = 0; m_sio[g] = 0; m_lat[g] = 0; end
        void'($urandom(32'h5EED_0007));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_pads("R1 reset");
        cfg_read_chk("R1 base hi", 8'h07, 8'h62);
        cfg_read_chk("R1 base lo", 8'h07, 8'h63);

        // R2 foreign logical device
        cfg_write(8'h05, 8'hC8, 8'hFF);
        chk_pads("R2 foreign write");
        cfg_write(8'h07, 8'hC9, 8'h3C);
        cfg_read_chk("R2 foreign read", 8'h06, 8'hC9);
        cfg_read_chk("R4 oe readback", 8'h07, 8'hC9);
        chk_pads("R4 oe pads");

        // R8 port disabled at base 0
        io_write(16'h0000, 8'h77);
        io_write(16'h0003, 8'h55);
        chk_pads("R8 disabled write");
        io_read_chk("R8 disabled read", 16'h0001);

        // R3 staged high byte
        cfg_write(8'h07, 8'h62, 8'h0A);
        cfg_read_chk("R3 hi staged only", 8'h07, 8'h62);
        cfg_write(8'h07, 8'h62, 8'h0B);
        cfg_write(8'h07, 8'h63, 8'h00);
        cfg_read_chk("R3 hi committed", 8'h07, 8'h62);
        cfg_write(8'h07, 8'h63, 8'h10);
        cfg_read_chk("R3 lo only", 8'h07, 8'h63);

        // R4 R6 R7 drive and read
        cfg_write(8'h07, 8'hCA, 8'hF0);
        ext = 64'h0123_4567_89AB_CDEF;
        io_write(16'h0B12, 8'hA5);
        chk_pads("R6 latch group2");
        io_read_chk("R7 mixed read", 16'h0B12);
        io_read_chk("R7 input group0", 16'h0B10);

        // R5 mode registers
        cfg_write(8'h07, 8'hC5, 8'hFF);
        cfg_read_chk("R5 unimpl read", 8'h07, 8'hC5);
        cfg_write(8'h07, 8'hC1, 8'h81);
        cfg_read_chk("R5 sio readback", 8'h07, 8'hC1);
        chk_pads("R5 sio pads");

        // R9 window edges
        io_write(16'h0B18, 8'hEE);
        io_write(16'h0B0F, 8'hDD);
        chk_pads("R9 outside window");
        io_read_chk("R9 read past end", 16'h0B18);
        cfg_write(8'h07, 8'h62, 8'hFF);
        cfg_write(8'h07, 8'h63, 8'hFC);
        io_write(16'hFFFF, 8'h3E);
        io_write(16'h0003, 8'hC3);
        chk_pads("R9 top window no wrap");
        io_read_chk("R9 wrap read", 16'h0002);

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int r = $urandom_range(0, 9);
            ext = {$urandom(), $urandom()};
            if (r < 4) begin
                int s = $urandom_range(0, 19);
                logic [7:0] idx;
                logic [7:0] ldn = 8'h07;
                if (s == 0) idx = 8'h62;
                else if (s == 1) idx = 8'h63;
                else if (s < 10) idx = 8'(8'hC8 + s - 2);
                else if (s < 18) idx = 8'(8'hC0 + s - 10);
                else idx = 8'($urandom());
                if (s == 19) ldn = 8'($urandom_range(0, 6));
                cfg_write(ldn, idx, 8'($urandom()));
                chk_pads("R4 R5 random cfg");
                cfg_read_chk("R2 R3 random cfg read", 8'h07, idx);
            end else begin
                logic [15:0] a;
                if ($urandom_range(0, 3) != 0) a = m_base + 16'($urandom_range(0, 9));
                else a = 16'($urandom());
                if (r < 8) begin
                    io_write(a, 8'($urandom()));
                    chk_pads("R6 R9 random io write");
                end
                io_read_chk("R7 R8 random io read", a);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule